// File: doc/BRIEF.md
# Physical register free list

This block keeps the pools of unallocated physical register numbers for a renaming stage. There are three register classes: integer, floating-point and condition-code. All physical registers share one numbering. The integer numbers come first, the floating-point numbers follow directly after them, and the condition-code numbers follow after those. Each class has its own first-in, first-out pool. The oldest number returned to a pool is the next one that pool hands out.

Each class has an allocate strobe. The pool's head number is shown without a clock edge while that class's availability flag is high, and raising the strobe consumes that number at the next edge. A single release port takes back one number per cycle. A classifier compares the number against the class boundaries and steers it into the matching pool. At reset every pool is loaded with all of its class's numbers except the lowest few, which stay held for the initial architectural mappings.

A two-state fault machine watches for three illegal events: allocating from an empty pool, releasing into a full pool, and releasing a number outside every class. The states are `ERR_CLEAN` and `ERR_LATCHED`. The transition `fault_seen` goes from `ERR_CLEAN` to `ERR_LATCHED` on any illegal event. `ERR_LATCHED` has only a self-loop `hold` and is left only through reset. In `ERR_CLEAN` the self-loop `idle` is taken when no illegal event occurs.

Top module: `phys_reg_freelist`

## Requirements
- R1: After reset, the integer, floating-point and condition-code pools hold `N_INT-RSV_INT`, `N_FP-RSV_FP` and `N_CC-RSV_CC` entries. Each pool's head is its class base plus its reserve count. The class bases are 0, `N_INT` and `N_INT+N_FP`.
- R2: Each pool returns numbers in the order they entered it. Numbers seeded at reset come out in ascending order, ahead of any number released later.
- R3: A released number below `N_INT` goes to the integer pool. A number from `N_INT` up to `N_INT+N_FP-1` goes to the floating-point pool. A number from `N_INT+N_FP` up to `N_INT+N_FP+N_CC-1` goes to the condition-code pool.
- R4: A class's availability flag is high exactly when its count is nonzero. The head number is valid while the flag is high.
- R5: A count rises by one on a release into that pool and falls by one on an allocation from it. It stays unchanged when both happen in the same cycle, including when the pool is full.
- R6: A release into a full pool with no allocation from that pool in the same cycle is dropped. The count stays at the class size and the error output goes high.
- R7: An allocation from an empty pool changes nothing in the pool and raises the error output.
- R8: A released number at or above `N_INT+N_FP+N_CC` enters no pool and raises the error output.
- R9: The error output goes high on the clock edge that follows an illegal event. It stays high until reset and is low while all traffic is legal.
- R10: The three classes can each allocate in the same cycle, independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; seeds the pools |
| int_alloc | input | 1 | Consume the integer pool head |
| int_idx | output | IDX_W | Integer pool head number |
| int_avail | output | 1 | Integer pool is not empty |
| int_count | output | CNT_W | Integer pool occupancy |
| fp_alloc | input | 1 | Consume the floating-point pool head |
| fp_idx | output | IDX_W | Floating-point pool head number |
| fp_avail | output | 1 | Floating-point pool is not empty |
| fp_count | output | CNT_W | Floating-point pool occupancy |
| cc_alloc | input | 1 | Consume the condition-code pool head |
| cc_idx | output | IDX_W | Condition-code pool head number |
| cc_avail | output | 1 | Condition-code pool is not empty |
| cc_count | output | CNT_W | Condition-code pool occupancy |
| rel_valid | input | 1 | A number is being released this cycle |
| rel_idx | input | IDX_W | Released physical number |
| err | output | 1 | Sticky illegal-event flag |

## Verification
The bench builds the block with 6 integer, 5 floating-point and 3 condition-code registers, with 2, 1 and 0 of them reserved. The numbering is then 4 bits wide, and the numbers 14 and 15 lie outside every class, so R8 can be exercised. The condition-code pool starts full and holds only three entries. That makes the full-pool release with and without a same-cycle allocation reachable in one step, and it takes only three allocations to empty the pool. A reserve of zero in one class and nonzero reserves in the others cover both seeding shapes. All class sizes are not powers of two, so every pointer wraps explicitly.

// File: rtl/regfl_pkg.sv
package regfl_pkg;

    // Which pool a released number belongs to
    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_CC   = 2'd2,
        CLS_NONE = 2'd3
    } pool_cls_e;

    // Fault tracking states
    typedef enum logic {
        ERR_CLEAN   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_e;

endpackage

// File: rtl/regfl_classify.sv
module regfl_classify
    import regfl_pkg::*;
#(
    parameter int unsigned N_INT = 32,
    parameter int unsigned N_FP  = 32,
    parameter int unsigned N_CC  = 8,
    parameter int unsigned IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx,
    output pool_cls_e        cls
);

    // Upper bounds, one bit wider so the total never wraps
    localparam logic [IDX_W:0] LIM_INT = (IDX_W+1)'(N_INT);
    localparam logic [IDX_W:0] LIM_FP  = (IDX_W+1)'(N_INT + N_FP);
    localparam logic [IDX_W:0] LIM_CC  = (IDX_W+1)'(N_INT + N_FP + N_CC);

    logic [IDX_W:0] wide_idx;
    assign wide_idx = {1'b0, idx};

    always_comb begin
        if (wide_idx < LIM_INT)      cls = CLS_INT;
        else if (wide_idx < LIM_FP)  cls = CLS_FP;
        else if (wide_idx < LIM_CC)  cls = CLS_CC;
        else                         cls = CLS_NONE;
    end

endmodule

// File: rtl/regfl_pool.sv
module regfl_pool #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned RSV   = 0,
    parameter int unsigned BASE  = 0,
    parameter int unsigned IDX_W = 7,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_req,
    input  logic             push_req,
    input  logic [IDX_W-1:0] push_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic             avail,
    output logic [CNT_W-1:0] count,
    output logic             pop_err,
    output logic             push_err
);

    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned SEED = DEPTH - RSV;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [IDX_W-1:0] slots [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok, push_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok   = pop_req && (cnt_q != '0);
    assign push_ok  = push_req && ((cnt_q != FULL) || pop_ok);
    assign pop_err  = pop_req && (cnt_q == '0);
    assign push_err = push_req && !push_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++)
                slots[i] <= (i < int'(SEED)) ? IDX_W'(BASE + RSV + i) : '0;
            rd_ptr <= '0;
            wr_ptr <= PW'(SEED % DEPTH);
            cnt_q  <= CNT_W'(SEED);
        end else begin
            if (push_ok) begin
                slots[wr_ptr] <= push_idx;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop_ok)
                rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_idx = slots[rd_ptr];
    assign avail    = (cnt_q != '0);
    assign count    = cnt_q;

endmodule

// File: rtl/regfl_err_fsm.sv
module regfl_err_fsm
    import regfl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic err
);

    err_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAN:   if (fault) state_d = ERR_LATCHED;  // fault_seen
            ERR_LATCHED: state_d = ERR_LATCHED;             // hold
            default:     state_d = ERR_LATCHED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAN:   err = 1'b0;
            ERR_LATCHED: err = 1'b1;
            default:     err = 1'b1;
        endcase
    end

endmodule

// File: rtl/phys_reg_freelist.sv
module phys_reg_freelist
    import regfl_pkg::*;
#(
    parameter int unsigned N_INT   = 32,
    parameter int unsigned N_FP    = 32,
    parameter int unsigned N_CC    = 8,
    parameter int unsigned RSV_INT = 16,
    parameter int unsigned RSV_FP  = 16,
    parameter int unsigned RSV_CC  = 4,
    localparam int unsigned TOTAL  = N_INT + N_FP + N_CC,
    localparam int unsigned IDX_W  = $clog2(TOTAL),
    localparam int unsigned MAXN   = (N_INT > N_FP) ? ((N_INT > N_CC) ? N_INT : N_CC)
                                                    : ((N_FP > N_CC) ? N_FP : N_CC),
    localparam int unsigned CNT_W  = $clog2(MAXN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_alloc,
    output logic [IDX_W-1:0] int_idx,
    output logic             int_avail,
    output logic [CNT_W-1:0] int_count,
    input  logic             fp_alloc,
    output logic [IDX_W-1:0] fp_idx,
    output logic             fp_avail,
    output logic [CNT_W-1:0] fp_count,
    input  logic             cc_alloc,
    output logic [IDX_W-1:0] cc_idx,
    output logic             cc_avail,
    output logic [CNT_W-1:0] cc_count,
    input  logic             rel_valid,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             err
);

    localparam int unsigned NCLS = 3;
    localparam int unsigned DEPTH_A [NCLS] = '{N_INT, N_FP, N_CC};
    localparam int unsigned RSV_A   [NCLS] = '{RSV_INT, RSV_FP, RSV_CC};
    localparam int unsigned BASE_A  [NCLS] = '{0, N_INT, N_INT + N_FP};

    pool_cls_e        rel_cls;
    logic [NCLS-1:0]  alloc_v, push_v, avail_v, pop_err_v, push_err_v;
    logic [IDX_W-1:0] head_v [NCLS];
    logic [CNT_W-1:0] cnt_v  [NCLS];
    logic             stray, fault;

    regfl_classify #(
        .N_INT(N_INT), .N_FP(N_FP), .N_CC(N_CC), .IDX_W(IDX_W)
    ) u_classify (
        .idx (rel_idx),
        .cls (rel_cls)
    );

    assign alloc_v = {cc_alloc, fp_alloc, int_alloc};

    for (genvar g = 0; g < int'(NCLS); g++) begin : g_pool
        assign push_v[g] = rel_valid && (rel_cls == pool_cls_e'(g));

        regfl_pool #(
            .DEPTH(DEPTH_A[g]), .RSV(RSV_A[g]), .BASE(BASE_A[g]),
            .IDX_W(IDX_W), .CNT_W(CNT_W)
        ) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .pop_req  (alloc_v[g]),
            .push_req (push_v[g]),
            .push_idx (rel_idx),
            .head_idx (head_v[g]),
            .avail    (avail_v[g]),
            .count    (cnt_v[g]),
            .pop_err  (pop_err_v[g]),
            .push_err (push_err_v[g])
        );
    end

    assign stray = rel_valid && (rel_cls == CLS_NONE);
    assign fault = stray || (|pop_err_v) || (|push_err_v);

    regfl_err_fsm u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (fault),
        .err   (err)
    );

    assign int_idx   = head_v[0];
    assign fp_idx    = head_v[1];
    assign cc_idx    = head_v[2];
    assign int_avail = avail_v[0];
    assign fp_avail  = avail_v[1];
    assign cc_avail  = avail_v[2];
    assign int_count = cnt_v[0];
    assign fp_count  = cnt_v[1];
    assign cc_count  = cnt_v[2];

endmodule

// File: rtl/regfl_checker.sv
module regfl_checker #(
    parameter int unsigned N_INT = 32,
    parameter int unsigned N_FP  = 32,
    parameter int unsigned N_CC  = 8,
    parameter int unsigned IDX_W = 7,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_alloc,
    input logic [IDX_W-1:0] int_idx,
    input logic             int_avail,
    input logic [CNT_W-1:0] int_count,
    input logic             fp_alloc,
    input logic [IDX_W-1:0] fp_idx,
    input logic             fp_avail,
    input logic [CNT_W-1:0] fp_count,
    input logic             cc_alloc,
    input logic [IDX_W-1:0] cc_idx,
    input logic             cc_avail,
    input logic [CNT_W-1:0] cc_count,
    input logic             rel_valid,
    input logic [IDX_W-1:0] rel_idx,
    input logic             err
);

    localparam logic [IDX_W:0] B_FP  = (IDX_W+1)'(N_INT);
    localparam logic [IDX_W:0] B_CC  = (IDX_W+1)'(N_INT + N_FP);
    localparam logic [IDX_W:0] B_END = (IDX_W+1)'(N_INT + N_FP + N_CC);

    logic int_rel;
    assign int_rel = rel_valid && ({1'b0, rel_idx} < B_FP);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_count <= CNT_W'(N_INT)) && (fp_count <= CNT_W'(N_FP)) && (cc_count <= CNT_W'(N_CC)));

    assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_empty_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_alloc && !cc_avail) |=> err);

    assert_stray_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && ({1'b0, rel_idx} >= B_END)) |=> err);

    assert_quiet_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_alloc && !int_rel) |=> $stable(int_count));

    assert_fp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_avail && !err) |-> (({1'b0, fp_idx} >= B_FP) && ({1'b0, fp_idx} < B_CC)));

    assert_cc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_avail && !err) |-> (({1'b0, cc_idx} >= B_CC) && ({1'b0, cc_idx} < B_END)));

endmodule

bind phys_reg_freelist regfl_checker #(
    .N_INT(N_INT), .N_FP(N_FP), .N_CC(N_CC), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_regfl_checker (
    .clk(clk), .rst_n(rst_n),
    .int_alloc(int_alloc), .int_idx(int_idx), .int_avail(int_avail), .int_count(int_count),
    .fp_alloc(fp_alloc), .fp_idx(fp_idx), .fp_avail(fp_avail), .fp_count(fp_count),
    .cc_alloc(cc_alloc), .cc_idx(cc_idx), .cc_avail(cc_avail), .cc_count(cc_count),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .err(err)
);

// File: tb/test_phys_reg_freelist.sv
module test_phys_reg_freelist;

    localparam int NI = 6, NF = 5, NC = 3;
    localparam int RI = 2, RF = 1, RC = 0;
    localparam int TOT = NI + NF + NC;
    localparam int IW = 4, CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          int_alloc = 1'b0, fp_alloc = 1'b0, cc_alloc = 1'b0;
    logic          rel_valid = 1'b0;
    logic [IW-1:0] rel_idx = '0;
    logic [IW-1:0] int_idx, fp_idx, cc_idx;
    logic          int_avail, fp_avail, cc_avail, err;
    logic [CW-1:0] int_count, fp_count, cc_count;

    always #5 clk = ~clk;

    phys_reg_freelist #(
        .N_INT(NI), .N_FP(NF), .N_CC(NC), .RSV_INT(RI), .RSV_FP(RF), .RSV_CC(RC)
    ) i_phys_reg_freelist (
        .clk(clk), .rst_n(rst_n),
        .int_alloc(int_alloc), .int_idx(int_idx), .int_avail(int_avail), .int_count(int_count),
        .fp_alloc(fp_alloc), .fp_idx(fp_idx), .fp_avail(fp_avail), .fp_count(fp_count),
        .cc_alloc(cc_alloc), .cc_idx(cc_idx), .cc_avail(cc_avail), .cc_count(cc_count),
        .rel_valid(rel_valid), .rel_idx(rel_idx), .err(err)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // Behavioural reference: one queue per class
    int  mq [3][$];
    bit  m_err;
    int  cap  [3] = '{NI, NF, NC};
    int  base [3] = '{0, NI, NI + NF};
    int  rsv  [3] = '{RI, RF, RC};
    bit  busy [TOT];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int class_of(input int n);
        if (n < NI) return 0;
        if (n < NI + NF) return 1;
        if (n < TOT) return 2;
        return 3;
    endfunction

    function automatic int dut_count(input int c);
        case (c)
            0: return int'(int_count);
            1: return int'(fp_count);
            default: return int'(cc_count);
        endcase
    endfunction

    function automatic int dut_idx(input int c);
        case (c)
            0: return int'(int_idx);
            1: return int'(fp_idx);
            default: return int'(cc_idx);
        endcase
    endfunction

    function automatic bit dut_avail(input int c);
        case (c)
            0: return int_avail;
            1: return fp_avail;
            default: return cc_avail;
        endcase
    endfunction

    task automatic compare_all();
        for (int c = 0; c < 3; c++) begin
            chk(dut_count(c) == mq[c].size(), "R5 count", dut_count(c), mq[c].size());
            chk(dut_avail(c) == (mq[c].size() != 0), "R4 avail", int'(dut_avail(c)),
                int'(mq[c].size() != 0));
            if (mq[c].size() != 0)
                chk(dut_idx(c) == mq[c][0], "R2 head order", dut_idx(c), mq[c][0]);
        end
        chk(err == m_err, "R9 err", int'(err), int'(m_err));
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            mq[c].delete();
            for (int k = rsv[c]; k < cap[c]; k++) mq[c].push_back(base[c] + k);
        end
        for (int n = 0; n < TOT; n++) busy[n] = 1'b0;
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < rsv[c]; k++) busy[base[c] + k] = 1'b1;
        m_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        int_alloc = 0; fp_alloc = 0; cc_alloc = 0; rel_valid = 0; rel_idx = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic step(input bit ai, input bit af, input bit ac, input bit rv, input int ri);
        bit [2:0] al;
        int rc;
        @(negedge clk);
        int_alloc = ai; fp_alloc = af; cc_alloc = ac;
        rel_valid = rv; rel_idx = IW'(ri);
        #1 compare_all();
        @(posedge clk);
        al = {ac, af, ai};
        for (int c = 0; c < 3; c++) begin
            if (al[c]) begin
                if (mq[c].size() > 0) void'(mq[c].pop_front());
                else m_err = 1'b1;
            end
        end
        if (rv) begin
            rc = class_of(ri);
            if (rc == 3) m_err = 1'b1;
            else if (mq[rc].size() < cap[rc]) mq[rc].push_back(ri);
            else m_err = 1'b1;
        end
        #1;
        int_alloc = 0; fp_alloc = 0; cc_alloc = 0; rel_valid = 0;
    endtask

    task automatic peek();
        @(negedge clk);
        #1 compare_all();
    endtask

    initial begin : main
        do_reset();

        // R1: seeded contents
        @(negedge clk); #1;
        chk(int_count == 3'd4, "R1 int count", int'(int_count), 4);
        chk(fp_count == 3'd4, "R1 fp count", int'(fp_count), 4);
        chk(cc_count == 3'd3, "R1 cc count", int'(cc_count), 3);
        chk(int_idx == 4'd2, "R1 int head", int'(int_idx), 2);
        chk(fp_idx == 4'd7, "R1 fp head", int'(fp_idx), 7);
        chk(cc_idx == 4'd11, "R1 cc head", int'(cc_idx), 11);
        chk(err == 1'b0, "R1 err", int'(err), 0);
        compare_all();

        // R10: all three classes allocate together
        step(1, 1, 1, 0, 0);
        peek();
        chk(int_count == 3'd3 && fp_count == 3'd3 && cc_count == 3'd2, "R10 counts",
            int'(int_count) * 100 + int'(fp_count) * 10 + int'(cc_count), 332);

        // R3: steering by range
        step(0, 0, 0, 1, 2);
        peek();
        chk(int_count == 3'd4, "R3 int steer", int'(int_count), 4);
        step(0, 0, 0, 1, 7);
        peek();
        chk(fp_count == 3'd4, "R3 fp steer", int'(fp_count), 4);
        step(0, 0, 0, 1, 11);
        peek();
        chk(cc_count == 3'd3, "R3 cc steer", int'(cc_count), 3);
        chk(err == 1'b0, "R3 no err", int'(err), 0);

        // R2/R4/R5/R9: legal random traffic
        do_reset();
        for (int cyc = 0; cyc < 400; cyc++) begin
            bit ai, af, ac, rv;
            int r;
            ai = ($urandom % 2 == 1) && (mq[0].size() > 0);
            af = ($urandom % 2 == 1) && (mq[1].size() > 0);
            ac = ($urandom % 3 == 0) && (mq[2].size() > 0);
            r  = int'($urandom % TOT);
            rv = busy[r] && ($urandom % 2 == 1);
            if (ai) busy[mq[0][0]] = 1'b1;
            if (af) busy[mq[1][0]] = 1'b1;
            if (ac) busy[mq[2][0]] = 1'b1;
            if (rv) busy[r] = 1'b0;
            step(ai, af, ac, rv, r);
        end
        peek();
        chk(err == 1'b0, "R9 legal traffic err low", int'(err), 0);

        // R5: alloc and release on the same pool in one cycle
        do_reset();
        step(1, 0, 0, 1, 0);
        peek();
        chk(int_count == 3'd4, "R5 same-cycle count", int'(int_count), 4);
        chk(int_idx == 4'd3, "R5 head advanced", int'(int_idx), 3);

        // R5: full pool, alloc plus release together is legal
        do_reset();
        step(0, 0, 1, 1, 11);
        peek();
        chk(cc_count == 3'd3, "R5 full swap count", int'(cc_count), 3);
        chk(cc_idx == 4'd12, "R5 full swap head", int'(cc_idx), 12);
        chk(err == 1'b0, "R5 full swap err", int'(err), 0);

        // R6: overflow of a full pool
        do_reset();
        step(0, 0, 0, 1, 12);
        peek();
        chk(cc_count == 3'd3, "R6 overflow count", int'(cc_count), 3);
        chk(cc_idx == 4'd11, "R6 overflow head", int'(cc_idx), 11);
        chk(err == 1'b1, "R6 overflow err", int'(err), 1);

        // R7: underflow, then R9 stickiness
        do_reset();
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        peek();
        chk(cc_avail == 1'b0, "R7 cc drained", int'(cc_avail), 0);
        chk(err == 1'b0, "R7 no err yet", int'(err), 0);
        step(0, 0, 1, 0, 0);
        peek();
        chk(cc_count == 3'd0, "R7 underflow count", int'(cc_count), 0);
        chk(err == 1'b1, "R7 underflow err", int'(err), 1);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 2);
        peek();
        chk(err == 1'b1, "R9 sticky", int'(err), 1);
        do_reset();
        peek();
        chk(err == 1'b0, "R9 cleared by reset", int'(err), 0);

        // R8: out-of-range release
        step(0, 0, 0, 1, 14);
        peek();
        chk(int_count == 3'd4 && fp_count == 3'd4 && cc_count == 3'd3, "R8 counts untouched",
            int'(int_count) * 100 + int'(fp_count) * 10 + int'(cc_count), 443);
        chk(err == 1'b1, "R8 err", int'(err), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule